// File: doc/BRIEF.md
# Power Sequencing Glue Controller

This block gathers the small pieces of board-level power-state logic into one clocked module. It produces an active-low reset for the always-on resume well and holds it for a programmable time after the standby rail is reported good. If the rail drops out, the reset returns at once. When the rail recovers, the full hold time is counted again from the new good indication.

The block also drives two open-drain outputs. The first pulls the backfeed-cut line low once the main supply is good and the system has left the S3 sleep state. The second pulls the supply-enable line low whenever a processor is fitted and the system is out of S3. Each open-drain output appears as a drive-low enable: 1 means the pin is pulled low, 0 means it floats.

A latched backfeed flag records that the backfeed-cut line was released. The flag is cleared when the S5 sleep signal falls. A 3.3 V power-good output is also produced from the supply power-good and the front-panel reset. Time is measured in pulses of a single-cycle tick input, which normally marks one millisecond.

Top module: `pwr_seq_glue`

## Requirements
- R1: While `rst_n` is low, every drive-low enable, `bfc_latched` and `pgood_3v` are 0, and `resume_rst_n` is 0.
- R2: With `stby_good` high, `resume_rst_n` stays 0 until `DELAY_TICKS` tick pulses have been counted. It reads 1 in the cycle after the clock edge that samples the last of those ticks.
- R3: When `stby_good` is 0, `resume_rst_n` is 0 in the same cycle, with no clock edge needed.
- R4: A dip of `stby_good` clears the count, so after recovery a full `DELAY_TICKS` ticks are needed again before release.
- R5: `bfc_pull_low` is 1 one clock after `psu_pgood`=1 and `slp_s3_n`=1 are both sampled. It is 0 for every other input combination.
- R6: `sup_pull_low` is 1 one clock after `cpu_present_n`=0 and `slp_s3_n`=1 are sampled. It is 0 otherwise.
- R7: `pgood_3v` is the AND of `psu_pgood` and `fp_rst_n`, registered once.
- R8: `bfc_latched` becomes 1 one clock after `bfc_pull_low` falls from 1 to 0, and then holds. It does not set when `bfc_pull_low` rises.
- R9: `bfc_latched` returns to 0 one clock after a falling `slp_s5_n` is sampled. When a set and a clear fall on the same edge, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle timebase pulse |
| stby_good | input | 1 | Standby rail above its trip point |
| slp_s3_n | input | 1 | S3 sleep request, active low |
| slp_s5_n | input | 1 | S5 sleep request, active low |
| psu_pgood | input | 1 | Main supply power-good |
| fp_rst_n | input | 1 | Front-panel reset, active low |
| cpu_present_n | input | 1 | Processor fitted, active low |
| resume_rst_n | output | 1 | Resume-well reset, active low |
| bfc_pull_low | output | 1 | Drive-low enable for the backfeed-cut line |
| sup_pull_low | output | 1 | Drive-low enable for the supply-enable line |
| bfc_latched | output | 1 | Latched backfeed-cut flag |
| pgood_3v | output | 1 | Registered power-good |

## Verification
The following properties are checked on every cycle:
- The resume reset is low whenever the rail is down.
- The resume reset never releases before a full tick count has built up since the last rail recovery.
- Both pull-low enables match the inputs sampled one cycle earlier.
- The power-good output matches its inputs from one cycle earlier.
- The latch only sets after the backfeed enable has been released.

Some behaviour can only be shown by the bench's scenarios:
- The reset releases on exactly the last tick.
- A brown-out in the middle of a count restarts the wait from zero.
- The flag holds across later input activity.
- A clear beats a set that lands on the same edge.

// File: rtl/pwr_glue_pkg.sv
package pwr_glue_pkg;
  typedef struct packed {
    logic bfc;
    logic supply;
  } od_en_t;
endpackage

// File: rtl/pwr_rst_stretch.sv
module pwr_rst_stretch #(
  parameter int DELAY_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stby_good,
  output logic rst_out_n
);
  localparam int CNT_W = $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done;

  assign done = (cnt_q == LIMIT);

  // Count is held at zero while the rail is down; saturates at LIMIT.
  always_comb begin
    cnt_d = cnt_q;
    if (!stby_good) begin
      cnt_d = '0;
    end else if (tick && !done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Rail loss reasserts the reset without waiting for a clock edge.
  assign rst_out_n = stby_good & done;
endmodule

// File: rtl/pwr_od_drive.sv
module pwr_od_drive
  import pwr_glue_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   psu_pgood,
  input  logic   slp_s3_n,
  input  logic   cpu_present_n,
  input  logic   fp_rst_n,
  output od_en_t en_q,
  output logic   pgood_q
);
  od_en_t en_d;
  logic   pgood_d;

  always_comb begin
    en_d.bfc    = psu_pgood & slp_s3_n;
    en_d.supply = ~cpu_present_n & slp_s3_n;
    pgood_d     = psu_pgood & fp_rst_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pgood_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      pgood_q <= pgood_d;
    end
  end
endmodule

// File: rtl/pwr_bfc_latch.sv
module pwr_bfc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic bfc_en,
  input  logic slp_s5_n,
  output logic latched
);
  logic en_prev_q, s5_prev_q, latched_q;
  logic set_evt, clr_evt, latched_d;

  assign set_evt = en_prev_q & ~bfc_en;
  assign clr_evt = s5_prev_q & ~slp_s5_n;

  // A clear on the same edge as a set takes priority.
  always_comb begin
    latched_d = latched_q;
    if (clr_evt) begin
      latched_d = 1'b0;
    end else if (set_evt) begin
      latched_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev_q <= 1'b0;
      s5_prev_q <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      en_prev_q <= bfc_en;
      s5_prev_q <= slp_s5_n;
      latched_q <= latched_d;
    end
  end

  assign latched = latched_q;
endmodule

// File: rtl/pwr_seq_glue.sv
module pwr_seq_glue
  import pwr_glue_pkg::*;
#(
  parameter int DELAY_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic stby_good,
  input  logic slp_s3_n,
  input  logic slp_s5_n,
  input  logic psu_pgood,
  input  logic fp_rst_n,
  input  logic cpu_present_n,
  output logic resume_rst_n,
  output logic bfc_pull_low,
  output logic sup_pull_low,
  output logic bfc_latched,
  output logic pgood_3v
);
  od_en_t od_en;

  pwr_rst_stretch #(.DELAY_TICKS(DELAY_TICKS)) u_stretch (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .stby_good (stby_good),
    .rst_out_n (resume_rst_n)
  );

  pwr_od_drive u_od (
    .clk           (clk),
    .rst_n         (rst_n),
    .psu_pgood     (psu_pgood),
    .slp_s3_n      (slp_s3_n),
    .cpu_present_n (cpu_present_n),
    .fp_rst_n      (fp_rst_n),
    .en_q          (od_en),
    .pgood_q       (pgood_3v)
  );

  pwr_bfc_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .bfc_en   (od_en.bfc),
    .slp_s5_n (slp_s5_n),
    .latched  (bfc_latched)
  );

  assign bfc_pull_low = od_en.bfc;
  assign sup_pull_low = od_en.supply;
endmodule

// File: rtl/pwr_seq_glue_chk.sv
module pwr_seq_glue_chk #(
  parameter int DELAY_TICKS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic stby_good,
  input logic slp_s3_n,
  input logic slp_s5_n,
  input logic psu_pgood,
  input logic fp_rst_n,
  input logic cpu_present_n,
  input logic resume_rst_n,
  input logic bfc_pull_low,
  input logic sup_pull_low,
  input logic bfc_latched,
  input logic pgood_3v
);
  localparam int CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(DELAY_TICKS);

  // Ticks seen since the rail last came up (independent observer).
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (!stby_good) begin
      seen_q <= '0;
    end else if (tick && seen_q != FULL) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  // R3
  p_rail_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_good |-> !resume_rst_n);

  // R2, R4
  p_no_early_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q != FULL) |-> !resume_rst_n);

  // R5
  p_bfc_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bfc_pull_low |-> $past(psu_pgood && slp_s3_n));

  // R6
  p_supply_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sup_pull_low |-> $past(!cpu_present_n && slp_s3_n));

  // R7
  p_pgood_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pgood_3v |-> $past(psu_pgood && fp_rst_n));

  // R8
  p_latch_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bfc_latched) |-> ($past(bfc_pull_low, 2) && !$past(bfc_pull_low)));

  // R9
  p_latch_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slp_s5_n) |=> !bfc_latched);
endmodule

bind pwr_seq_glue pwr_seq_glue_chk #(.DELAY_TICKS(DELAY_TICKS)) u_chk (.*);

// File: tb/pwr_seq_glue_test.sv
module pwr_seq_glue_test;
  localparam int DLY = 32;

  logic clk = 1'b0;
  logic rst_n, tick, stby_good, slp_s3_n, slp_s5_n, psu_pgood, fp_rst_n, cpu_present_n;
  logic resume_rst_n, bfc_pull_low, sup_pull_low, bfc_latched, pgood_3v;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_glue #(.DELAY_TICKS(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stby_good(stby_good),
    .slp_s3_n(slp_s3_n), .slp_s5_n(slp_s5_n), .psu_pgood(psu_pgood),
    .fp_rst_n(fp_rst_n), .cpu_present_n(cpu_present_n),
    .resume_rst_n(resume_rst_n), .bfc_pull_low(bfc_pull_low),
    .sup_pull_low(sup_pull_low), .bfc_latched(bfc_latched), .pgood_3v(pgood_3v)
  );

  // {psu_pgood, slp_s3_n, cpu_present_n, fp_rst_n, exp_bfc, exp_sup, exp_pg}
  localparam logic [6:0] VEC [8] = '{
    7'b0000_000, 7'b0001_000, 7'b0100_010, 7'b0110_000,
    7'b1000_000, 7'b1001_001, 7'b1101_111, 7'b1110_100
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; stby_good = 1'b1; slp_s3_n = 1'b1;
    slp_s5_n = 1'b1; psu_pgood = 1'b1; fp_rst_n = 1'b1; cpu_present_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: inputs would drive everything, yet all stay inactive in reset
    chk("R1 resume_rst_n", resume_rst_n, 1'b0);
    chk("R1 bfc_pull_low", bfc_pull_low, 1'b0);
    chk("R1 sup_pull_low", sup_pull_low, 1'b0);
    chk("R1 bfc_latched",  bfc_latched,  1'b0);
    chk("R1 pgood_3v",     pgood_3v,     1'b0);
    stby_good = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R7: table walk
    for (int v = 0; v < 8; v++) begin
      {psu_pgood, slp_s3_n, cpu_present_n, fp_rst_n} = VEC[v][6:3];
      @(negedge clk);
      chk("R5 bfc_pull_low", bfc_pull_low, VEC[v][2]);
      chk("R6 sup_pull_low", sup_pull_low, VEC[v][1]);
      chk("R7 pgood_3v",     pgood_3v,     VEC[v][0]);
    end

    // R2: release exactly on the last tick
    stby_good = 1'b1;
    @(negedge clk);
    pulse_ticks(DLY - 1);
    chk("R2 before last tick", resume_rst_n, 1'b0);
    pulse_ticks(1);
    chk("R2 after last tick", resume_rst_n, 1'b1);

    // R3: immediate reassert without a clock edge
    #2 stby_good = 1'b0;
    #1 chk("R3 same-cycle reassert", resume_rst_n, 1'b0);
    @(negedge clk);

    // R4: brown-out mid-count restarts the delay
    stby_good = 1'b1;
    pulse_ticks(DLY / 2);
    stby_good = 1'b0;
    @(negedge clk);
    stby_good = 1'b1;
    pulse_ticks(DLY - 1);
    chk("R4 restarted count not done", resume_rst_n, 1'b0);
    pulse_ticks(1);
    chk("R4 full count after recovery", resume_rst_n, 1'b1);

    // R8: latch sets on release of the backfeed enable, not on its rise
    slp_s5_n = 1'b1; psu_pgood = 1'b0; slp_s3_n = 1'b0;
    repeat (2) @(negedge clk);
    slp_s5_n = 1'b0;
    @(negedge clk);
    slp_s5_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 cleared before test", bfc_latched, 1'b0);
    psu_pgood = 1'b1; slp_s3_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 no set on enable rise", bfc_latched, 1'b0);
    slp_s3_n = 1'b0;
    @(negedge clk);
    chk("R8 enable released", bfc_pull_low, 1'b0);
    @(negedge clk);
    chk("R8 latch set", bfc_latched, 1'b1);
    slp_s3_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 latch holds", bfc_latched, 1'b1);

    // R9: clear on S5 fall
    slp_s5_n = 1'b0;
    @(negedge clk);
    chk("R9 cleared by S5 fall", bfc_latched, 1'b0);

    // R9: clear wins over a set on the same edge
    slp_s5_n = 1'b1;
    repeat (2) @(negedge clk);
    slp_s3_n = 1'b0;
    @(negedge clk);
    slp_s5_n = 1'b0;
    @(negedge clk);
    chk("R9 clear beats set", bfc_latched, 1'b0);
    @(negedge clk);
    chk("R9 stays clear", bfc_latched, 1'b0);

    finish_run();
  end
endmodule